// File: doc/BRIEF.md
# Accumulating Interrupt and Barrier Register Unit

This unit sits beside one processor and holds three signalling registers: one for interrupts sent by other processors, one for interrupts raised on completion of device requests, and one for barrier synchronisation. Incoming writes never overwrite a register; their data is merged into it with a bitwise OR, so several senders can post distinct bits without coordinating. A local read returns the register and empties it in the same access, so software consumes every posted bit exactly once.

Writes arrive with two masks: one selecting stations and one selecting processor slots within each station. The unit takes a write only when both the bit for its own station and the bit for its own slot are set, so a single write can be delivered to any set of processors. The two interrupt registers each drive an interrupt line that is high while the register holds any set bit. The barrier register raises no interrupt; instead it flags when every bit in a programmable participant mask has been set, so a processor that has posted its own bit to all participants can wait on that flag.

Top module: `sigreg_unit`

## Requirements
- R1: After a synchronous reset, all three registers are zero and the interrupt lines, barrier flag and read-valid output are low.
- R2: A taken write ORs its data into the selected register; bits already set are kept until a read clears them.
- R3: A taken write of non-zero data to the cross-processor register (select 0) or the device register (select 1) sets that register's interrupt line on the next cycle; each line stays high while its register is non-zero.
- R4: A read (rd_i with select 0, 1 or 2) returns the register's contents on rd_data_o, with rd_valid_o high, one cycle later, clears the register and drops its interrupt line; without a read, rd_data_o is zero.
- R5: A write to the barrier register (select 2) leaves both interrupt lines unchanged.
- R6: A write is taken only when wr_stn_mask_i has the bit at index my_stn_i set and wr_cpu_mask_i has the bit at index my_cpu_i set; any number of other mask bits may also be set.
- R7: When a read and a taken write hit the same register in one cycle, the read returns the old contents and the written bits remain in the register afterwards.
- R8: bar_done_o is high one cycle after the barrier register holds every bit of a non-zero part_mask_i, and low whenever the mask is zero or a participant bit is missing.
- R9: Select code 3 names no register: a write with it changes nothing and a read with it returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_stn_i | input | STN_W | Index of this processor's station |
| my_cpu_i | input | CPU_W | Index of this processor within its station |
| wr_i | input | 1 | Incoming write strobe |
| wr_sel_i | input | 2 | Target register of the write (0 cross-proc, 1 device, 2 barrier, 3 none) |
| wr_stn_mask_i | input | N_STN | Station routing mask of the write |
| wr_cpu_mask_i | input | N_CPU | Per-station processor mask of the write |
| wr_data_i | input | DATA_W | Bits to OR into the target |
| rd_i | input | 1 | Local read-and-clear strobe |
| rd_sel_i | input | 2 | Register to read, same coding as wr_sel_i |
| part_mask_i | input | DATA_W | Barrier participant mask |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DATA_W | Read data (contents before the clear) |
| irq_xproc_o | output | 1 | Cross-processor interrupt line |
| irq_dev_o | output | 1 | Device interrupt line |
| bar_done_o | output | 1 | All barrier participants have arrived |

## Verification
The assertions take for granted that my_stn_i and my_cpu_i are held constant outside reset and lie inside the mask widths, and that each input holds at most one write and one read per cycle. The bench fixes the identity at station 2, slot 1, drives every input on the falling edge, and keeps random masks and selects within their declared widths, including code 3, while it changes the participant mask only between operations so that the barrier flag can be predicted from the register contents.

// File: rtl/sigreg_pkg.sv
package sigreg_pkg;
  localparam int SEL_W = 2;
  localparam int NREG  = 3;
  localparam int NIRQ  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_XPROC = 2'd0,
    SEL_DEV   = 2'd1,
    SEL_BAR   = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;
endpackage

// File: rtl/sigreg_match.sv
module sigreg_match
  import sigreg_pkg::*;
#(
  parameter int N_STN = 4,
  parameter int N_CPU = 4,
  localparam int STN_W = (N_STN > 1) ? $clog2(N_STN) : 1,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_STN-1:0] stn_mask_i,
  input  logic [N_CPU-1:0] cpu_mask_i,
  input  logic [STN_W-1:0] my_stn_i,
  input  logic [CPU_W-1:0] my_cpu_i,
  output logic [NREG-1:0]  set_o
);
  logic hit;

  assign hit = wr_i & stn_mask_i[my_stn_i] & cpu_mask_i[my_cpu_i];

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign set_o[i] = hit && (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/sigreg_cell.sv
module sigreg_cell #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic [DATA_W-1:0] set_data_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] q_o,
  output logic [DATA_W-1:0] nxt_o
);
  logic [DATA_W-1:0] q;

  // clear applies to the old contents only; bits arriving now survive
  assign nxt_o = (clr_i ? '0 : q) | (set_i ? set_data_i : '0);
  assign q_o   = q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assert_or_keep_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((q & $past(q)) == $past(q)));

  assert_race_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i) |=> (q == $past(set_data_i)));
endmodule

// File: rtl/sigreg_unit.sv
module sigreg_unit
  import sigreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_STN  = 4,
  parameter int N_CPU  = 4,
  localparam int STN_W = (N_STN > 1) ? $clog2(N_STN) : 1,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STN_W-1:0]  my_stn_i,
  input  logic [CPU_W-1:0]  my_cpu_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [N_STN-1:0]  wr_stn_mask_i,
  input  logic [N_CPU-1:0]  wr_cpu_mask_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic [DATA_W-1:0] part_mask_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_xproc_o,
  output logic              irq_dev_o,
  output logic              bar_done_o
);
  logic [NREG-1:0]   set;
  logic [NREG-1:0]   clr;
  logic [DATA_W-1:0] q   [NREG];
  logic [DATA_W-1:0] nxt [NREG];
  logic [NIRQ-1:0]   irq_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              done_q;

  sigreg_match #(.N_STN(N_STN), .N_CPU(N_CPU)) u_match (
    .wr_i       (wr_i),
    .sel_i      (wr_sel_i),
    .stn_mask_i (wr_stn_mask_i),
    .cpu_mask_i (wr_cpu_mask_i),
    .my_stn_i   (my_stn_i),
    .my_cpu_i   (my_cpu_i),
    .set_o      (set)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign clr[i] = rd_i && (rd_sel_i == SEL_W'(i));

    sigreg_cell #(.DATA_W(DATA_W)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .set_i      (set[i]),
      .set_data_i (wr_data_i),
      .clr_i      (clr[i]),
      .q_o        (q[i]),
      .nxt_o      (nxt[i])
    );
  end

  // interrupt lines follow the register contents being written this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
    end else begin
      for (int i = 0; i < NIRQ; i++) irq_q[i] <= |nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_i;
      rd_data_q  <= '0;
      if (rd_i) begin
        case (sel_e'(rd_sel_i))
          SEL_XPROC: rd_data_q <= q[0];
          SEL_DEV:   rd_data_q <= q[1];
          SEL_BAR:   rd_data_q <= q[2];
          default:   rd_data_q <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= (part_mask_i != '0) &&
                       ((nxt[2] & part_mask_i) == part_mask_i);
  end

  assign irq_xproc_o = irq_q[0];
  assign irq_dev_o   = irq_q[1];
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign bar_done_o  = done_q;

  assert_irq_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    (set[0] && (wr_data_i != '0)) |=> irq_xproc_o);

  assert_dev_irq_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    (set[1] && (wr_data_i != '0)) |=> irq_dev_o);

  assert_read_drops_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (clr[0] && !set[0]) |=> !irq_xproc_o);

  assert_read_valid_R4: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rd_valid_o);

  assert_barrier_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (set[2] && !rd_i) |=> ($stable(irq_xproc_o) && $stable(irq_dev_o)));

  assert_done_needs_part_R8: assert property (@(posedge clk) disable iff (rst)
    bar_done_o |-> ($past(part_mask_i) != '0));

  assert_none_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (wr_sel_i == SEL_NONE) && !rd_i) |=>
      ($stable(irq_xproc_o) && $stable(irq_dev_o)));
endmodule

// File: tb/sim_sigreg_unit.sv
`timescale 1ns/1ps
module sim_sigreg_unit;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    my_stn = 2'd2;
  logic [1:0]    my_cpu = 2'd1;
  logic          wr = 1'b0;
  logic [1:0]    wsel = 2'd0;
  logic [3:0]    smask = 4'd0;
  logic [3:0]    cmask = 4'd0;
  logic [DW-1:0] wdata = '0;
  logic          rd = 1'b0;
  logic [1:0]    rsel = 2'd0;
  logic [DW-1:0] part = '0;
  logic          rd_valid, irq_x, irq_d, done;
  logic [DW-1:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sigreg_unit u0 (
    .clk(clk), .rst(rst), .my_stn_i(my_stn), .my_cpu_i(my_cpu),
    .wr_i(wr), .wr_sel_i(wsel), .wr_stn_mask_i(smask), .wr_cpu_mask_i(cmask),
    .wr_data_i(wdata), .rd_i(rd), .rd_sel_i(rsel), .part_mask_i(part),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .irq_xproc_o(irq_x),
    .irq_dev_o(irq_d), .bar_done_o(done)
  );

  // behavioural reference
  logic [DW-1:0] m_reg [3];
  logic          m_irq_x, m_irq_d, m_done, m_rdv;
  logic [DW-1:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) m_reg[i] = '0;
      m_irq_x = 0; m_irq_d = 0; m_done = 0; m_rdv = 0; m_rdata = '0;
    end else begin
      bit taken;
      taken = wr && smask[my_stn] && cmask[my_cpu];
      m_rdv = rd;
      m_rdata = (rd && rsel != 2'd3) ? m_reg[rsel] : '0;
      for (int i = 0; i < 3; i++) begin
        if (rd && rsel == i) m_reg[i] = '0;
        if (taken && wsel == i) m_reg[i] = m_reg[i] | wdata;
      end
      m_irq_x = (m_reg[0] != 0);
      m_irq_d = (m_reg[1] != 0);
      m_done = (part != 0) && ((m_reg[2] & part) == part);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R3 irq_xproc model", irq_x, m_irq_x);
      check("R3 irq_dev model", irq_d, m_irq_d);
      check("R4 rd_valid model", rd_valid, m_rdv);
      check("R4 rd_data model", rd_data, m_rdata);
      check("R8 bar_done model", done, m_done);
    end
  end

  task automatic cyc(bit w, logic [1:0] ws, logic [3:0] sm, logic [3:0] cm,
                     logic [DW-1:0] d, bit r, logic [1:0] rs);
    @(negedge clk);
    wr = w; wsel = ws; smask = sm; cmask = cm; wdata = d; rd = r; rsel = rs;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, '0, 0, 0);
  endtask

  // read one register, leaving rd_data_o valid for checking
  task automatic rd_reg(logic [1:0] s);
    cyc(0, 0, 0, 0, '0, 1, s);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    check("R1 irq_xproc after reset", irq_x, 0);
    check("R1 irq_dev after reset", irq_d, 0);
    check("R1 bar_done after reset", done, 0);
    check("R1 rd_valid after reset", rd_valid, 0);
    rd_reg(2'd1);
    check("R1 device reg zero", rd_data, 0);

    // R3 / R2: accumulate into cross-processor register
    cyc(1, 0, 4'b0100, 4'b0010, 16'h0001, 0, 0);
    idle();
    check("R3 irq after write", irq_x, 1);
    cyc(1, 0, 4'b0100, 4'b0010, 16'h0100, 0, 0);
    rd_reg(2'd0);
    check("R2 OR accumulate", rd_data, 16'h0101);
    check("R4 rd_valid", rd_valid, 1);
    check("R4 irq dropped", irq_x, 0);
    rd_reg(2'd0);
    check("R4 cleared", rd_data, 0);

    // R6: mask filtering
    cyc(1, 0, 4'b1011, 4'b1111, 16'h00F0, 0, 0);
    idle();
    check("R6 station miss", irq_x, 0);
    cyc(1, 0, 4'b1111, 4'b1101, 16'h00F0, 0, 0);
    idle();
    check("R6 cpu miss", irq_x, 0);
    cyc(1, 0, 4'b1111, 4'b1111, 16'h0A00, 0, 0);
    rd_reg(2'd0);
    check("R6 multicast accepted", rd_data, 16'h0A00);

    // R5 / R8: barrier
    part = 16'h000F;
    cyc(1, 2, 4'b0100, 4'b0010, 16'h0001, 0, 0);
    cyc(1, 2, 4'b1111, 4'b0010, 16'h0006, 0, 0);
    idle();
    check("R5 no xproc irq from barrier", irq_x, 0);
    check("R5 no dev irq from barrier", irq_d, 0);
    check("R8 not all arrived", done, 0);
    cyc(1, 2, 4'b0100, 4'b1111, 16'h0008, 0, 0);
    idle();
    check("R8 all arrived", done, 1);
    rd_reg(2'd2);
    check("R4 barrier read", rd_data, 16'h000F);
    check("R8 cleared by read", done, 0);

    // R7: same-cycle read and write
    cyc(1, 1, 4'b0100, 4'b0010, 16'h0003, 0, 0);
    cyc(1, 1, 4'b0100, 4'b0010, 16'h00F0, 1, 1);
    idle();
    check("R7 old value returned", rd_data, 16'h0003);
    check("R7 irq kept", irq_d, 1);
    rd_reg(2'd1);
    check("R7 new bits kept", rd_data, 16'h00F0);

    // R9: select code 3
    cyc(1, 3, 4'b1111, 4'b1111, 16'hFFFF, 0, 0);
    idle();
    check("R9 write ignored", {irq_x, irq_d}, 0);
    cyc(1, 0, 4'b0100, 4'b0010, 16'h0040, 0, 0);
    rd_reg(2'd3);
    check("R9 read returns zero", rd_data, 0);
    check("R9 nothing cleared", irq_x, 1);
    rd_reg(2'd0);
    check("R9 reg intact", rd_data, 16'h0040);

    // mixed random traffic against the reference
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) begin
        @(negedge clk);
        part = DW'($urandom_range(0, 15));
      end
      cyc(($urandom % 3) != 0, 2'($urandom), 4'($urandom | 4'b0100 * ($urandom % 2)),
          4'($urandom), DW'($urandom & 32'h0000_00FF), ($urandom % 4) == 0, 2'($urandom));
    end
    idle();
    idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule